// File: doc/BRIEF.md
# Interrupt Pin Request and Delivery Unit

This unit collects interrupt requests from a set of input pins, each of which may be driven by several independent request sources, and turns them into interrupt messages for the processor side. Every pin keeps a pending bit. A per-pin trigger mode, mask bit and remote-acknowledge bit decide whether a request becomes a message or is merged into one already outstanding. Each outcome is reported back to the requester as accepted or coalesced.

Messages leave the unit one at a time on a valid/ready channel. The fields of each message come from the pin's routing entry: destination, vector, destination mode, trigger mode and delivery kind. When a level-triggered message is taken and the receiving side reports at least one destination hit, the pin's remote-acknowledge bit is set. It stays set until the end-of-interrupt logic elsewhere pulses its clear input. A readback vector shows the pending pins and leaves out edge requests that have already been delivered.

Top module: `irq_pin_deliver`

## Requirements
- R1: A pin's line is the OR of its per-source request bits. An event writes one source bit on one pin. A clear-source command zeroes that source's bit on every pin, and a set event in the same cycle wins over the clear for its own bit. Whenever a pin's line becomes low, its pending bit (and readback bit) is cleared and no new message is raised for it.
- R2: An edge pin (trigger bit 0) whose pending bit is clear accepts an assertion: the pending bit is set and exactly one message is raised. If the pending bit is already set, the assertion is coalesced and no further message is raised.
- R3: A level pin (trigger bit 1) whose remote-acknowledge bit is set reports every assertion as coalesced and raises no message. While its line is high, it is unmasked and remote-acknowledge is clear, it keeps being offered, including again after a hand-off with no destination hit.
- R4: A pin whose mask bit is 1 raises no message while masked, and its pending bit stays visible on the readback.
- R5: Each message carries the pin's destination, vector, destination mode, trigger bit and delivery kind exactly as configured when it was raised, with `msg_assert` high.
- R6: A level message handed off (valid and ready high) with `msg_hit` high sets the pin's remote-acknowledge bit. With `msg_hit` low it is left clear. A pulse on `rirr_clr` clears it.
- R7: Handing off an edge message marks the pin delivered, which forces its readback bit to 0. Any later assertion on that pin clears the delivered mark.
- R8: When several pins are eligible in the same cycle, the lowest-numbered one is raised. Only one message is outstanding, and it holds pin and fields stable until taken.
- R9: `ev_done` is high in the cycle after each event. `ev_coalesced` is high then exactly when the event left the line high and was coalesced under R2 or R3. An event that leaves the line high counts as an assertion.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ev_valid | input | 1 | Request event strobe |
| ev_pin | input | PIN_W | Pin addressed by the event |
| ev_src | input | SRC_W | Source whose bit is written |
| ev_level | input | 1 | New value of that source bit |
| clr_valid | input | 1 | Clear-source command strobe |
| clr_src | input | SRC_W | Source cleared on all pins |
| cfg_mask | input | NPINS | Per-pin mask |
| cfg_level | input | NPINS | Per-pin trigger (1 = level) |
| cfg_dmode | input | NPINS | Per-pin destination mode |
| cfg_vector | input | NPINS*VEC_W | Per-pin vector, pin p at bits p*VEC_W |
| cfg_dest | input | NPINS*DST_W | Per-pin destination |
| cfg_dlv | input | NPINS*DLV_W | Per-pin delivery kind |
| rirr_clr | input | NPINS | Clear pulse for remote-acknowledge bits |
| msg_valid | output | 1 | Message offered |
| msg_ready | input | 1 | Receiver takes the message |
| msg_hit | input | 1 | At least one destination accepted |
| msg_pin | output | PIN_W | Pin that raised the message |
| msg_dest | output | DST_W | Destination |
| msg_vector | output | VEC_W | Vector |
| msg_dmode | output | 1 | Destination mode |
| msg_trig | output | 1 | Trigger bit of the message |
| msg_dlv | output | DLV_W | Delivery kind |
| msg_assert | output | 1 | Assert flag of the message |
| ev_done | output | 1 | Event outcome valid |
| ev_coalesced | output | 1 | Event was coalesced |
| pend_view | output | NPINS | Pending bits without delivered edges |
| rirr | output | NPINS | Remote-acknowledge bits |

## Verification
Some properties are checked on every cycle. A pin with no active source never holds a pending bit. Remote-acknowledge and delivered marks rise only after the matching hand-off. A raised message always belongs to an unmasked pin with no lower eligible pin, and an untaken message stays stable. Other behaviour shows only in the bench scenarios: the coalesced verdict returned to the requester, re-offering a level pin after a refused hand-off or a remote-acknowledge clear, the readback change as edges are delivered and re-asserted, and a clear-source command that drops some pins while others stay high through a second source.

// File: rtl/irq_pin_pkg.sv
package irq_pin_pkg;
  localparam int VEC_W = 8;
  localparam int DST_W = 8;
  localparam int DLV_W = 3;

  typedef struct packed {
    logic [DST_W-1:0] dest;
    logic [VEC_W-1:0] vector;
    logic             dmode;
    logic             trig;
    logic [DLV_W-1:0] dlv;
  } route_t;
endpackage

// File: rtl/irq_src_matrix.sv
module irq_src_matrix #(
  parameter int NPINS = 8,
  parameter int NSRC  = 4,
  parameter int PIN_W = 3,
  parameter int SRC_W = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ev_valid,
  input  logic [PIN_W-1:0] ev_pin,
  input  logic [SRC_W-1:0] ev_src,
  input  logic             ev_level,
  input  logic             clr_valid,
  input  logic [SRC_W-1:0] clr_src,
  output logic [NPINS-1:0] line_next,
  output logic [NPINS-1:0] line_cur
);
  logic [NSRC-1:0] bits_q [NPINS];
  logic [NSRC-1:0] bits_n [NPINS];

  always_comb begin
    for (int p = 0; p < NPINS; p++) begin
      bits_n[p] = bits_q[p];
      if (clr_valid) bits_n[p][clr_src] = 1'b0;
      if (ev_valid && ev_pin == PIN_W'(p)) bits_n[p][ev_src] = ev_level;
      line_next[p] = |bits_n[p];
      line_cur[p]  = |bits_q[p];
    end
  end

  always_ff @(posedge clk) begin
    for (int p = 0; p < NPINS; p++) begin
      if (!rst_n) bits_q[p] <= '0;
      else        bits_q[p] <= bits_n[p];
    end
  end
endmodule

// File: rtl/irq_pin_slot.sv
module irq_pin_slot (
  input  logic clk,
  input  logic rst_n,
  input  logic line_next,
  input  logic line_cur,
  input  logic ev_here,
  input  logic is_level,
  input  logic masked,
  input  logic load,
  input  logic hs_edge,
  input  logic hs_lvl_hit,
  input  logic rirr_clr,
  output logic elig,
  output logic coal,
  output logic pend_vis,
  output logic rirr
);
  logic pend_q, arm_q, dlv_q, rirr_q;
  logic assert_ev;

  assign assert_ev = ev_here & line_next;
  assign coal      = assert_ev & (is_level ? rirr_q : pend_q);
  assign elig      = ~masked & (is_level ? (pend_q & ~rirr_q) : arm_q);
  assign pend_vis  = pend_q & ~dlv_q;
  assign rirr      = rirr_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pend_q <= 1'b0;
      arm_q  <= 1'b0;
      dlv_q  <= 1'b0;
      rirr_q <= 1'b0;
    end else begin
      pend_q <= line_next & (pend_q | assert_ev);
      arm_q  <= line_next & ((arm_q & ~load) | (assert_ev & ~is_level & ~pend_q));
      if (assert_ev && !is_level) dlv_q <= 1'b0;
      else if (hs_edge)           dlv_q <= 1'b1;
      if (hs_lvl_hit)             rirr_q <= 1'b1;
      else if (rirr_clr)          rirr_q <= 1'b0;
    end
  end

  a_r1_line_low: assert property (@(posedge clk) disable iff (!rst_n)
    !line_cur |-> !pend_q);
  a_r6_rirr_rise: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rirr_q) |-> $past(hs_lvl_hit));
  a_r7_dlv_rise: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(dlv_q) |-> $past(hs_edge));
endmodule

// File: rtl/irq_msg_arb.sv
module irq_msg_arb
  import irq_pin_pkg::*;
#(
  parameter int NPINS = 8,
  parameter int PIN_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NPINS-1:0] elig,
  input  route_t           routes [NPINS],
  input  logic             msg_ready,
  output logic             msg_valid,
  output logic [PIN_W-1:0] msg_pin,
  output route_t           msg_info,
  output logic [NPINS-1:0] grant
);
  function automatic logic [PIN_W-1:0] first_index(input logic [NPINS-1:0] v);
    first_index = '0;
    for (int i = NPINS - 1; i >= 0; i--)
      if (v[i]) first_index = PIN_W'(i);
  endfunction

  logic             load;
  logic [PIN_W-1:0] pick;

  assign load  = ~msg_valid & (|elig);
  assign pick  = first_index(elig);
  assign grant = load ? (NPINS'(1) << pick) : '0;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      msg_valid <= 1'b0;
      msg_pin   <= '0;
      msg_info  <= '0;
    end else if (load) begin
      msg_valid <= 1'b1;
      msg_pin   <= pick;
      msg_info  <= routes[pick];
    end else if (msg_ready) begin
      msg_valid <= 1'b0;
    end
  end

  a_r8_hold: assert property (@(posedge clk) disable iff (!rst_n)
    msg_valid && !msg_ready |=> msg_valid && $stable(msg_pin) && $stable(msg_info));
endmodule

// File: rtl/irq_pin_deliver.sv
module irq_pin_deliver
  import irq_pin_pkg::*;
#(
  parameter int NPINS = 8,
  parameter int NSRC  = 4,
  localparam int PIN_W = (NPINS > 1) ? $clog2(NPINS) : 1,
  localparam int SRC_W = (NSRC > 1) ? $clog2(NSRC) : 1
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   ev_valid,
  input  logic [PIN_W-1:0]       ev_pin,
  input  logic [SRC_W-1:0]       ev_src,
  input  logic                   ev_level,
  input  logic                   clr_valid,
  input  logic [SRC_W-1:0]       clr_src,
  input  logic [NPINS-1:0]       cfg_mask,
  input  logic [NPINS-1:0]       cfg_level,
  input  logic [NPINS-1:0]       cfg_dmode,
  input  logic [NPINS*VEC_W-1:0] cfg_vector,
  input  logic [NPINS*DST_W-1:0] cfg_dest,
  input  logic [NPINS*DLV_W-1:0] cfg_dlv,
  input  logic [NPINS-1:0]       rirr_clr,
  output logic                   msg_valid,
  input  logic                   msg_ready,
  input  logic                   msg_hit,
  output logic [PIN_W-1:0]       msg_pin,
  output logic [DST_W-1:0]       msg_dest,
  output logic [VEC_W-1:0]       msg_vector,
  output logic                   msg_dmode,
  output logic                   msg_trig,
  output logic [DLV_W-1:0]       msg_dlv,
  output logic                   msg_assert,
  output logic                   ev_done,
  output logic                   ev_coalesced,
  output logic [NPINS-1:0]       pend_view,
  output logic [NPINS-1:0]       rirr
);
  logic [NPINS-1:0] line_next, line_cur, elig, coal, grant;
  route_t           routes [NPINS];
  route_t           info;
  logic             hs;

  irq_src_matrix #(.NPINS(NPINS), .NSRC(NSRC), .PIN_W(PIN_W), .SRC_W(SRC_W)) u_src (
    .clk(clk), .rst_n(rst_n), .ev_valid(ev_valid), .ev_pin(ev_pin), .ev_src(ev_src),
    .ev_level(ev_level), .clr_valid(clr_valid), .clr_src(clr_src),
    .line_next(line_next), .line_cur(line_cur));

  assign hs = msg_valid & msg_ready;

  for (genvar p = 0; p < NPINS; p++) begin : g_pin
    logic here, mine;
    assign routes[p] = '{dest:   cfg_dest[p*DST_W +: DST_W],
                         vector: cfg_vector[p*VEC_W +: VEC_W],
                         dmode:  cfg_dmode[p],
                         trig:   cfg_level[p],
                         dlv:    cfg_dlv[p*DLV_W +: DLV_W]};
    assign here = ev_valid & (ev_pin == PIN_W'(p));
    assign mine = hs & (msg_pin == PIN_W'(p));

    irq_pin_slot u_slot (
      .clk(clk), .rst_n(rst_n), .line_next(line_next[p]), .line_cur(line_cur[p]),
      .ev_here(here), .is_level(cfg_level[p]), .masked(cfg_mask[p]), .load(grant[p]),
      .hs_edge(mine & ~info.trig), .hs_lvl_hit(mine & info.trig & msg_hit),
      .rirr_clr(rirr_clr[p]), .elig(elig[p]), .coal(coal[p]),
      .pend_vis(pend_view[p]), .rirr(rirr[p]));
  end

  irq_msg_arb #(.NPINS(NPINS), .PIN_W(PIN_W)) u_arb (
    .clk(clk), .rst_n(rst_n), .elig(elig), .routes(routes), .msg_ready(msg_ready),
    .msg_valid(msg_valid), .msg_pin(msg_pin), .msg_info(info), .grant(grant));

  assign msg_dest   = info.dest;
  assign msg_vector = info.vector;
  assign msg_dmode  = info.dmode;
  assign msg_trig   = info.trig;
  assign msg_dlv    = info.dlv;
  assign msg_assert = msg_valid;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ev_done      <= 1'b0;
      ev_coalesced <= 1'b0;
    end else begin
      ev_done      <= ev_valid;
      ev_coalesced <= |coal;
    end
  end

  a_r4_unmasked_only: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(msg_valid) |-> (($past(cfg_mask) >> msg_pin) & NPINS'(1)) == '0);
  a_r8_lowest: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(msg_valid) |-> ($past(elig) & ((NPINS'(1) << msg_pin) - NPINS'(1))) == '0);
  a_r9_coal_needs_event: assert property (@(posedge clk) disable iff (!rst_n)
    ev_coalesced |-> ev_done);
endmodule

// File: tb/irq_pin_deliver_tb.sv
module irq_pin_deliver_tb;
  localparam int NP = 8, NS = 4, VW = 8, DW = 8, LW = 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #5 clk = ~clk;

  logic ev_valid = 0, ev_level = 0, clr_valid = 0, msg_ready = 0, msg_hit = 0;
  logic [2:0] ev_pin = 0;
  logic [1:0] ev_src = 0, clr_src = 0;
  logic [NP-1:0] cfg_mask = 0, cfg_level = 0, cfg_dmode, rirr_clr = 0;
  logic [NP*VW-1:0] cfg_vector;
  logic [NP*DW-1:0] cfg_dest;
  logic [NP*LW-1:0] cfg_dlv;
  logic msg_valid, msg_dmode, msg_trig, msg_assert, ev_done, ev_coalesced;
  logic [2:0] msg_pin, msg_dlv;
  logic [DW-1:0] msg_dest;
  logic [VW-1:0] msg_vector;
  logic [NP-1:0] pend_view, rirr;

  always_comb begin
    for (int p = 0; p < NP; p++) begin
      cfg_vector[p*VW +: VW] = 8'h20 + 8'(p);
      cfg_dest[p*DW +: DW]   = 8'(p * 3 + 1);
      cfg_dlv[p*LW +: LW]    = 3'(p);
      cfg_dmode[p]           = p[0];
    end
  end

  irq_pin_deliver u_dut (
    .clk(clk), .rst_n(rst_n), .ev_valid(ev_valid), .ev_pin(ev_pin), .ev_src(ev_src),
    .ev_level(ev_level), .clr_valid(clr_valid), .clr_src(clr_src), .cfg_mask(cfg_mask),
    .cfg_level(cfg_level), .cfg_dmode(cfg_dmode), .cfg_vector(cfg_vector),
    .cfg_dest(cfg_dest), .cfg_dlv(cfg_dlv), .rirr_clr(rirr_clr), .msg_valid(msg_valid),
    .msg_ready(msg_ready), .msg_hit(msg_hit), .msg_pin(msg_pin), .msg_dest(msg_dest),
    .msg_vector(msg_vector), .msg_dmode(msg_dmode), .msg_trig(msg_trig),
    .msg_dlv(msg_dlv), .msg_assert(msg_assert), .ev_done(ev_done),
    .ev_coalesced(ev_coalesced), .pend_view(pend_view), .rirr(rirr));

  int total = 0, fails = 0;
  bit finished = 0;

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // Behavioural reference model, advanced on every rising edge
  bit m_src[NP][NS];
  bit m_pend[NP], m_arm[NP], m_dlv[NP], m_rirr[NP];
  bit m_mv, m_evd, m_evc, m_trig, m_dm;
  int m_pin, m_vec, m_dst, m_dk;

  always @(posedge clk) begin
    if (!rst_n) begin
      foreach (m_src[p, s]) m_src[p][s] = 0;
      for (int p = 0; p < NP; p++) begin
        m_pend[p] = 0; m_arm[p] = 0; m_dlv[p] = 0; m_rirr[p] = 0;
      end
      m_mv = 0; m_evd = 0; m_evc = 0; m_pin = 0;
      m_vec = 0; m_dst = 0; m_dk = 0; m_trig = 0; m_dm = 0;
    end else begin
      bit ns[NP][NS];
      bit line[NP];
      bit np[NP], na[NP], nd[NP], nr[NP];
      bit hs, c;
      int pk;
      hs = m_mv && msg_ready;
      pk = -1;
      if (!m_mv)
        for (int p = NP - 1; p >= 0; p--)
          if (!cfg_mask[p] && (cfg_level[p] ? (m_pend[p] && !m_rirr[p]) : m_arm[p])) pk = p;
      c = 0;
      for (int p = 0; p < NP; p++) begin
        bit asrt;
        line[p] = 0;
        for (int s = 0; s < NS; s++) begin
          ns[p][s] = m_src[p][s];
          if (clr_valid && clr_src == s) ns[p][s] = 0;
          if (ev_valid && ev_pin == p && ev_src == s) ns[p][s] = ev_level;
          if (ns[p][s]) line[p] = 1;
        end
        asrt = ev_valid && ev_pin == p && line[p];
        if (asrt && (cfg_level[p] ? m_rirr[p] : m_pend[p])) c = 1;
        np[p] = line[p] && (m_pend[p] || asrt);
        na[p] = line[p] && ((m_arm[p] && pk != p) || (asrt && !cfg_level[p] && !m_pend[p]));
        nd[p] = m_dlv[p];
        if (asrt && !cfg_level[p]) nd[p] = 0;
        else if (hs && m_pin == p && !m_trig) nd[p] = 1;
        nr[p] = m_rirr[p];
        if (hs && m_pin == p && m_trig && msg_hit) nr[p] = 1;
        else if (rirr_clr[p]) nr[p] = 0;
      end
      for (int p = 0; p < NP; p++) begin
        for (int s = 0; s < NS; s++) m_src[p][s] = ns[p][s];
        m_pend[p] = np[p]; m_arm[p] = na[p]; m_dlv[p] = nd[p]; m_rirr[p] = nr[p];
      end
      if (pk >= 0) begin
        m_mv = 1; m_pin = pk; m_vec = 32 + pk; m_dst = pk * 3 + 1;
        m_dk = pk % 8; m_trig = cfg_level[pk]; m_dm = pk[0];
      end else if (hs) m_mv = 0;
      m_evd = ev_valid;
      m_evc = c;
    end
  end

  // Cycle-by-cycle comparison against the model
  always @(negedge clk) begin
    if (rst_n && !finished) begin
      logic [NP-1:0] ev_pv, ev_rr;
      for (int p = 0; p < NP; p++) begin
        ev_pv[p] = m_pend[p] && !m_dlv[p];
        ev_rr[p] = m_rirr[p];
      end
      chk("R8 msg_valid", msg_valid, m_mv);
      if (m_mv) begin
        chk("R8 msg_pin", msg_pin, m_pin);
        chk("R5 fields", {msg_vector, msg_dest, msg_dlv, msg_trig, msg_dmode, msg_assert},
            {8'(m_vec), 8'(m_dst), 3'(m_dk), m_trig, m_dm, 1'b1});
      end
      chk("R9 ev_done", ev_done, m_evd);
      if (m_evd) chk("R9 ev_coalesced", ev_coalesced, m_evc);
      chk("R7 pend_view", pend_view, ev_pv);
      chk("R6 rirr", rirr, ev_rr);
    end
  end

  task automatic step(input int n = 1);
    repeat (n) @(negedge clk);
  endtask

  task automatic ev(input int pin, input int src, input bit lvl);
    @(negedge clk);
    ev_valid = 1; ev_pin = 3'(pin); ev_src = 2'(src); ev_level = lvl;
    @(negedge clk);
    ev_valid = 0;
  endtask

  task automatic take(input int pin, input bit hit, input string tag);
    int n = 0;
    while (!msg_valid && n < 8) begin step(); n++; end
    chk({tag, " offered"}, msg_valid, 1);
    chk({tag, " pin"}, msg_pin, pin);
    msg_ready = 1; msg_hit = hit;
    step();
    msg_ready = 0; msg_hit = 0;
  endtask

  initial begin
    cfg_level[1] = 1; cfg_level[3] = 1; cfg_level[5] = 1;
    step(3);
    rst_n = 1;
    step();
    chk("R8 reset msg_valid", msg_valid, 0);
    chk("R7 reset pend_view", pend_view, 0);
    chk("R6 reset rirr", rirr, 0);

    // R2 / R5: fresh edge on pin 2 accepted and delivered
    ev(2, 0, 1);
    chk("R9 done", ev_done, 1);
    chk("R2 fresh edge not coalesced", ev_coalesced, 0);
    step();
    chk("R5 vector", msg_vector, 8'h22);
    chk("R5 dest", msg_dest, 8'd7);
    chk("R5 dlv/trig/dmode", {msg_dlv, msg_trig, msg_dmode}, {3'd2, 1'b0, 1'b0});
    take(2, 0, "R2 edge");
    chk("R7 delivered edge hidden", pend_view[2], 0);
    ev(2, 1, 1);
    chk("R2 repeat edge coalesced", ev_coalesced, 1);
    chk("R7 new edge clears delivered", pend_view[2], 1);
    step(3);
    chk("R2 no second message", msg_valid, 0);
    ev(2, 0, 0);
    ev(2, 1, 0);
    chk("R1 line low clears pending", pend_view[2], 0);
    chk("R9 deassert not coalesced", ev_coalesced, 0);

    // R3 / R6: level pin 3
    ev(3, 0, 1);
    take(3, 1, "R6 level hit");
    chk("R6 remote ack set", rirr[3], 1);
    ev(3, 1, 1);
    chk("R3 coalesced on remote ack", ev_coalesced, 1);
    step(3);
    chk("R3 no message while acked", msg_valid, 0);
    @(negedge clk); rirr_clr[3] = 1;
    @(negedge clk); rirr_clr[3] = 0;
    chk("R6 clear pulse", rirr[3], 0);
    take(3, 0, "R3 reoffer");
    chk("R6 no hit leaves clear", rirr[3], 0);
    take(3, 1, "R3 reoffer after miss");
    chk("R6 set after second hand-off", rirr[3], 1);
    ev(3, 0, 0);
    ev(3, 1, 0);
    @(negedge clk); rirr_clr[3] = 1;
    @(negedge clk); rirr_clr[3] = 0;

    // R4: masked edge pin 4
    cfg_mask[4] = 1;
    ev(4, 0, 1);
    step(4);
    chk("R4 masked no message", msg_valid, 0);
    chk("R4 pending visible", pend_view[4], 1);
    ev(4, 0, 0);
    cfg_mask[4] = 0;
    step(2);
    chk("R4 nothing after unmask", msg_valid, 0);

    // R8: priority and hold
    ev(7, 0, 1);
    ev(6, 0, 1);
    ev(0, 0, 1);
    step(2);
    chk("R8 held pin", msg_pin, 3'd7);
    take(7, 0, "R8 first");
    take(0, 0, "R8 lowest next");
    take(6, 0, "R8 last");

    // R1: clear-source over all pins
    cfg_mask[5] = 1;
    ev(5, 0, 1);
    ev(1, 2, 1);
    take(1, 1, "R1 level pin1");
    ev(1, 0, 1);
    chk("R3 pin1 coalesced", ev_coalesced, 1);
    @(negedge clk); clr_valid = 1; clr_src = 0;
    @(negedge clk); clr_valid = 0;
    chk("R1 masked pin5 dropped", pend_view[5], 0);
    chk("R1 pin1 held by other source", pend_view[1], 1);
    chk("R1 pin1 remote ack kept", rirr[1], 1);
    step(4);
    chk("R1 no message after clear", msg_valid, 0);

    finished = 1;
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      total++; fails++;
      $display("FAIL watchdog: run did not finish actual=hung expected=done");
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
    end
  end
endmodule